// File: doc/BRIEF.md
# Synchronous Channel Deframer with Sync Monitor

This block sits on the receive side of a bit-serial synchronous link. Each clock cycle in which the data-enable input is high, it takes in one channel bit. It drops the zeros that the far end inserted after runs of five ones. It spots the two reserved codes: the flag, a zero, six ones and a zero; and the break, seven ones and a zero. It packs the remaining bits into fixed-width words for a downstream receive FIFO. Either reserved code throws away the partially assembled word, so the next bit starts a fresh word.

A sync monitor counts the data words delivered since the last flag. The far end sends a flag in place of every sixty-first word. If another data word arrives where that flag should have been, the framing-status output drops and stays low until a flag is seen again. Words are still delivered while framing is lost, and also before the first flag after reset.

Top module: `sync_deframer`

## Requirements
- R1: A 0 bit received right after five consecutive 1 bits is discarded and does not enter any word; all other bits (data values 0x00 to 0xFF) are passed on.
- R2: A 1 bit received after five or more consecutive 1 bits is kept. A raw run 0,1,1,1,1,1,1,1 on an aligned boundary yields the word 0xFE.
- R3: A 0, six 1s and a 0 (in time order) is a flag. It pulses `flag_o` for one cycle in the cycle after its last bit, drops the partial word, emits no word for itself, and the next kept bit becomes bit 0 of a new word.
- R4: `sync_o` goes high one cycle after a flag pulse. It stays high while each flag follows at most FRAME_WORDS (default 60) data words.
- R5: A data word that completes when FRAME_WORDS words have already followed the last flag drives `sync_o` low. `sync_o` then stays low until the next flag.
- R6: Words are delivered on `word_vld_o`/`word_o` whatever the state of `sync_o`.
- R7: During and after reset `sync_o`, `word_vld_o`, `flag_o` and `brk_o` are low. `sync_o` stays low until the first flag.
- R8: Seven or more 1s followed by a 0 is a break. It pulses `brk_o` for one cycle, emits no word, drops the partial word, and leaves `sync_o` unchanged.
- R9: A cycle with `den_i` low is ignored: no bit is taken, and no word, flag or break pulse follows.
- R10: Bits fill each word starting at bit 0: the first kept bit after a boundary lands in `word_o[0]`. `word_vld_o` pulses in the cycle after the word's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| den_i | input | 1 | Bit qualifier; the bit on `din_i` is taken when high |
| din_i | input | 1 | Serial channel bit |
| word_vld_o | output | 1 | One-cycle pulse: a recovered word is on `word_o` |
| word_o | output | WORD_W | Recovered data word |
| flag_o | output | 1 | One-cycle pulse: flag recognized |
| brk_o | output | 1 | One-cycle pulse: break recognized |
| sync_o | output | 1 | Framing status, high while periodic flags are seen |

## Verification
A flag can end on the very bit that would have completed a word. When the stream is aligned, the flag's eighth bit is also the eighth bit fed to the assembler. The bench sends flags directly after whole words, with random data-enable gaps in between, and judges the result by requiring that the word stream carries no extra word at that point. The same collision happens between the sixty-first word and the sync monitor: the bench sends exactly sixty words and then sixty-one words after a flag, and checks that the word is delivered while `sync_o` falls only in the second case.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
   // run lengths of 1s that carry meaning on the channel
   localparam int STUFF_RUN = 5;   // a 0 after this many 1s is filler
   localparam int FLAG_RUN  = 6;   // 0, six 1s, 0 closes a flag
   localparam int BREAK_RUN = 7;   // seven or more 1s then 0 closes a break
   localparam int RUN_W     = $clog2(BREAK_RUN + 1);

   typedef enum logic [1:0] {
      HIT_NONE  = 2'd0,
      HIT_FLAG  = 2'd1,
      HIT_BREAK = 2'd2
   } hit_e;
endpackage

// File: rtl/sdf_destuff.sv
module sdf_destuff
   import sdf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic den_i,
   input  logic din_i,
   output logic bit_vld_o,
   output logic bit_o,
   output hit_e hit_o
);
   logic [RUN_W-1:0] ones_q;
   logic             lead0_q;   // a received 0 opened the current run
   logic             stuffed;

   assign stuffed   = !din_i && (ones_q == RUN_W'(STUFF_RUN));
   assign bit_vld_o = den_i && !stuffed;
   assign bit_o     = din_i;

   always_comb begin
      hit_o = HIT_NONE;
      if (den_i && !din_i) begin
         if (ones_q == RUN_W'(BREAK_RUN))
            hit_o = HIT_BREAK;
         else if (ones_q == RUN_W'(FLAG_RUN) && lead0_q)
            hit_o = HIT_FLAG;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q  <= '0;
         lead0_q <= 1'b0;
      end else if (den_i) begin
         if (din_i) begin
            if (ones_q != RUN_W'(BREAK_RUN))
               ones_q <= ones_q + 1'b1;
         end else begin
            ones_q  <= '0;
            lead0_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sdf_assemble.sv
module sdf_assemble #(
   parameter int WORD_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld_i,
   input  logic              bit_i,
   input  logic              clear_i,
   output logic              word_vld_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int CNT_W = $clog2(WORD_W);

   logic [WORD_W-1:0] shr_q, shr_nx;
   logic [CNT_W-1:0]  cnt_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign shr_nx = {bit_i, shr_q[WORD_W-1:1]};
      end else begin : g_msb
         assign shr_nx = {shr_q[WORD_W-2:0], bit_i};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shr_q      <= '0;
         cnt_q      <= '0;
         word_vld_o <= 1'b0;
         word_o     <= '0;
      end else begin
         word_vld_o <= 1'b0;
         if (clear_i) begin
            cnt_q <= '0;
         end else if (bit_vld_i) begin
            shr_q <= shr_nx;
            if (cnt_q == CNT_W'(WORD_W - 1)) begin
               cnt_q      <= '0;
               word_vld_o <= 1'b1;
               word_o     <= shr_nx;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sdf_sync_mon.sv
module sdf_sync_mon #(
   parameter int FRAME_WORDS = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_i,
   input  logic word_i,
   output logic sync_o
);
   localparam int CNT_W = $clog2(FRAME_WORDS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_WORDS);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sync_o <= 1'b0;
      end else if (flag_i) begin
         cnt_q  <= '0;
         sync_o <= 1'b1;
      end else if (word_i) begin
         if (cnt_q == LAST)
            sync_o <= 1'b0;   // flag slot held data instead
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sync_deframer.sv
module sync_deframer
   import sdf_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int FRAME_WORDS = 60,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              den_i,
   input  logic              din_i,
   output logic              word_vld_o,
   output logic [WORD_W-1:0] word_o,
   output logic              flag_o,
   output logic              brk_o,
   output logic              sync_o
);
   initial begin
      if (WORD_W < 2)
         $fatal(1, "sync_deframer: WORD_W must be at least 2");
      if (FRAME_WORDS < 1)
         $fatal(1, "sync_deframer: FRAME_WORDS must be at least 1");
   end

   logic bit_vld, bit_val;
   hit_e hit;

   sdf_destuff u_destuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .den_i     (den_i),
      .din_i     (din_i),
      .bit_vld_o (bit_vld),
      .bit_o     (bit_val),
      .hit_o     (hit)
   );

   sdf_assemble #(.WORD_W(WORD_W), .LSB_FIRST(LSB_FIRST)) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_vld_i  (bit_vld),
      .bit_i      (bit_val),
      .clear_i    (hit != HIT_NONE),
      .word_vld_o (word_vld_o),
      .word_o     (word_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         brk_o  <= 1'b0;
      end else begin
         flag_o <= (hit == HIT_FLAG);
         brk_o  <= (hit == HIT_BREAK);
      end
   end

   sdf_sync_mon #(.FRAME_WORDS(FRAME_WORDS)) u_mon (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (flag_o),
      .word_i (word_vld_o),
      .sync_o (sync_o)
   );
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker (
   input logic clk,
   input logic rst_n,
   input logic den_i,
   input logic word_vld_o,
   input logic flag_o,
   input logic brk_o,
   input logic sync_o
);
   a_r3_flag_no_word: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o |-> !word_vld_o);

   a_r8_break_no_word: assert property (@(posedge clk) disable iff (!rst_n)
      brk_o |-> !word_vld_o);

   a_r8_break_not_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !(brk_o && flag_o));

   a_r4_sync_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o |=> sync_o);

   a_r5_sync_latched_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_o && !flag_o) |=> !sync_o);

   a_r9_idle_no_event: assert property (@(posedge clk) disable iff (!rst_n)
      !den_i |=> (!word_vld_o && !flag_o && !brk_o));

   a_r8_break_keeps_sync: assert property (@(posedge clk) disable iff (!rst_n)
      brk_o |=> (sync_o == $past(sync_o)));
endmodule

bind sync_deframer sdf_checker u_sdf_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .den_i      (den_i),
   .word_vld_o (word_vld_o),
   .flag_o     (flag_o),
   .brk_o      (brk_o),
   .sync_o     (sync_o)
);

// File: tb/test_sync_deframer.sv
`timescale 1ns/1ps
module test_sync_deframer;
   localparam int W  = 8;
   localparam int FW = 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic den = 1'b0;
   logic din = 1'b0;
   logic         word_vld, flag_p, brk_p, sync_s;
   logic [W-1:0] word;

   always #2.5 clk = ~clk;   // 200 MHz

   sync_deframer #(.WORD_W(W), .FRAME_WORDS(FW), .LSB_FIRST(1'b1)) i_sync_deframer (
      .clk(clk), .rst_n(rst_n), .den_i(den), .din_i(din),
      .word_vld_o(word_vld), .word_o(word), .flag_o(flag_p),
      .brk_o(brk_p), .sync_o(sync_s)
   );

   int n_chk = 0;
   int n_err = 0;
   int tx_ones = 0;
   int flag_seen = 0;
   int brk_seen = 0;
   logic [W-1:0] exp_q[$];
   logic [W-1:0] last_word = '0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // output monitor: every delivered word must be the next expected one
   always @(negedge clk) begin
      if (rst_n) begin
         if (flag_p) flag_seen++;
         if (brk_p)  brk_seen++;
         if (word_vld) begin
            last_word = word;
            if (exp_q.size() == 0)
               chk(1'b0, "R1/R3/R8 unexpected word", int'(word), 0);
            else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               chk(word == e, "R1/R6/R10 word value", int'(word), int'(e));
            end
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         din = 1'($urandom);
         den = 1'b0;
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic send_bit(input logic b);
      if ($urandom % 4 == 0) idle(int'($urandom % 3));
      din = b;
      den = 1'b1;
      @(posedge clk);
      @(negedge clk);
      den = 1'b0;
   endtask

   // raw bits, oldest first, no stuffing
   task automatic send_raw(input logic [7:0] pat, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) send_bit(pat[i]);
      tx_ones = 0;
   endtask

   task automatic send_flag();
      send_raw(8'b0111_1110, 8);
   endtask

   task automatic send_word(input logic [W-1:0] v);
      exp_q.push_back(v);
      for (int i = 0; i < W; i++) begin
         send_bit(v[i]);
         tx_ones = v[i] ? tx_ones + 1 : 0;
         if (tx_ones == 5) begin
            send_bit(1'b0);
            tx_ones = 0;
         end
      end
   endtask

   function automatic logic [W-1:0] rnd_word();
      return W'($urandom);
   endfunction

   initial begin
      #(150000 * 5);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R7: reset state while the channel toggles
      for (int i = 0; i < 6; i++) begin
         den = 1'b1;
         din = 1'($urandom);
         @(posedge clk);
         @(negedge clk);
      end
      chk(!sync_s && !word_vld && !flag_p && !brk_p, "R7 reset outputs",
          int'({sync_s, word_vld, flag_p, brk_p}), 0);
      den = 1'b0;
      rst_n = 1'b1;
      idle(3);
      chk(sync_s == 1'b0, "R7 sync low before first flag", int'(sync_s), 0);

      // R9: a flag pattern presented with den low is ignored
      for (int i = 0; i < 16; i++) begin
         din = (i % 8 == 0 || i % 8 == 7) ? 1'b0 : 1'b1;
         den = 1'b0;
         @(posedge clk);
         @(negedge clk);
      end
      idle(2);
      chk(flag_seen == 0, "R9 no flag while den low", flag_seen, 0);
      chk(sync_s == 1'b0, "R9 sync unchanged while den low", int'(sync_s), 0);

      // R3/R4: first flag establishes framing
      send_flag();
      idle(2);
      chk(flag_seen == 1, "R3 flag pulse", flag_seen, 1);
      chk(sync_s == 1'b1, "R4 sync high after flag", int'(sync_s), 1);

      // R1/R10: stuffing-heavy directed words, then random fill to 60
      send_word(8'hFF); send_word(8'h7E); send_word(8'h3F); send_word(8'hFC);
      send_word(8'h1F); send_word(8'hF8); send_word(8'h00); send_word(8'hA5);
      for (int i = 8; i < FW; i++) send_word(rnd_word());
      idle(2);
      chk(sync_s == 1'b1, "R4 sync high after 60 words", int'(sync_s), 1);
      chk(exp_q.size() == 0, "R1 all words delivered", exp_q.size(), 0);
      // R3: flag right after a word boundary wins, no extra word
      send_flag();
      idle(2);
      chk(sync_s == 1'b1, "R4 flag in time keeps sync", int'(sync_s), 1);
      chk(flag_seen == 2, "R3 second flag", flag_seen, 2);

      // R5/R6: 61 words, the last takes the flag slot
      for (int i = 0; i < FW; i++) send_word(rnd_word());
      idle(2);
      chk(sync_s == 1'b1, "R5 sync held at slot limit", int'(sync_s), 1);
      send_word(rnd_word());
      idle(2);
      chk(sync_s == 1'b0, "R5 sync lost on missing flag", int'(sync_s), 0);
      chk(exp_q.size() == 0, "R6 word delivered on loss", exp_q.size(), 0);
      for (int i = 0; i < 3; i++) send_word(rnd_word());
      idle(2);
      chk(sync_s == 1'b0, "R5 loss latched", int'(sync_s), 0);
      chk(exp_q.size() == 0, "R6 words delivered while lost", exp_q.size(), 0);

      // R8: break on an aligned boundary
      send_raw(8'b1111_1110, 8);
      idle(2);
      chk(brk_seen == 1, "R8 break pulse", brk_seen, 1);
      chk(sync_s == 1'b0, "R8 break leaves sync", int'(sync_s), 0);

      // R3: three stray bits misalign; the straddling word is 0xF5
      exp_q.push_back(8'hF5);
      send_raw(8'b0000_0101, 3);
      send_flag();
      idle(2);
      chk(sync_s == 1'b1, "R3 flag restores sync", int'(sync_s), 1);
      for (int i = 0; i < 5; i++) send_word(rnd_word());
      idle(2);
      chk(exp_q.size() == 0, "R3 realigned words", exp_q.size(), 0);

      // R2: a 1 after five 1s is kept
      exp_q.push_back(8'hFE);
      send_raw(8'b0111_1111, 8);
      idle(2);
      chk(last_word == 8'hFE, "R2 kept sixth and seventh 1", int'(last_word), 'hFE);
      send_flag();   // its leading 0 closes a run of seven 1s: a break
      idle(2);
      chk(brk_seen == 2, "R2 long run gives break", brk_seen, 2);
      chk(flag_seen == 4, "R3 flag after break", flag_seen, 4);
      for (int i = 0; i < 4; i++) send_word(rnd_word());
      idle(3);
      chk(exp_q.size() == 0, "R1 final words delivered", exp_q.size(), 0);
      chk(sync_s == 1'b1, "R4 final sync", int'(sync_s), 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule